// File: doc/BRIEF.md
# Direction-Aware Bridge Clock Gating Controller

This controller decides, per traffic direction, whether the root clock of each bridge domain of a bus-bridge interface may run. The bridge has an always-running core domain and two bridge domains. The master-side domain (index 0) carries inbound requests from the serial link toward the application. The slave-side domain (index 1) carries outbound requests from the application toward the link. Each bridge domain has a pending-request flag and a busy flag. When either is set, that domain's clock root is enabled. When both have stayed clear for a programmable number of core cycles, it is disabled again. Traffic that the core handles without the application leaves both bridge domains gated while the core keeps running. The decision uses only these request, busy and debug-override inputs. It never looks at the link's power-management state.

After an enable, a per-domain ready flag rises only once a programmable wake delay has passed. Request sources wait for this flag before handing traffic across. Each enable leaves the block through a latch that is transparent only while that domain's source clock is low, so the enable seen by the clock-gate cell never changes during a high phase. A force-on bit per domain keeps a domain running for debug.

Top module: `xgate_ctrl`

## Requirements
- R1: While `pend[0]` or `busy[0]` is high at a core rising edge, `en_req[0]` is high after that edge. Inbound activity alone never raises `en_req[1]`.
- R2: While `pend[1]` or `busy[1]` is high at a core rising edge, `en_req[1]` is high after that edge. Outbound activity alone never raises `en_req[0]`.
- R3: A domain's `en_req` falls only at an edge where its pending, busy and force inputs are all low. With no activity on either direction, both bridge enables and both ready flags end up low.
- R4: If `en_req[d]` rises at edge k, `rdy[d]` stays low until edge k+N and rises there. N is `wake_dly`, and a value of 0 selects the default of 4.
- R5: If a domain's activity is first seen low at edge j and stays low, `en_req` falls at edge j+H. H is `idle_hold`, and a value of 0 selects the default of 16. `rdy` stays high until that same edge. New activity during the hold window keeps the domain enabled and ready.
- R6: `gate_en[d]` changes only while `dom_clk[d]` is low. While `dom_clk[d]` is low it equals `en_req[d]`.
- R7: While `force_on[d]` is high, domain d is enabled from the next edge on, whatever the traffic.
- R8: After a synchronous active-low reset, `en_req`, `gate_en` and `rdy` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dom_clk | input | 2 | Ungated source clock of each bridge domain (0 master, 1 slave) |
| pend | input | 2 | Pending request per direction (0 inbound, 1 outbound) |
| busy | input | 2 | Bridge domain still processing, per direction |
| force_on | input | 2 | Debug override that keeps a domain enabled |
| wake_dly | input | 4 | Wake delay in core cycles, 0 selects 4 |
| idle_hold | input | 8 | Idle hysteresis in core cycles, 0 selects 16 |
| en_req | output | 2 | Core-domain enable request per domain |
| gate_en | output | 2 | Glitch-free enable for each root clock gate |
| rdy | output | 2 | Domain awake and able to accept traffic |

## Verification
The two functions that can coincide are the wake-up of one bridge domain and the hysteresis expiry of the other. The bench lets the slave side begin its idle countdown. It then raises an inbound request so that the request is first sampled on the very edge where the slave countdown ends. One sample after that edge must show the master enable rising and the slave enable and both ready flags low. The master ready flag must then appear exactly the wake delay later, unaffected by the gating-off on the other side.

// File: rtl/xgate_pkg.sv
`timescale 1ns/1ps
// Shared types for the bridge clock gating controller.
// Assumes two bridge domains: index 0 master side (inbound), index 1 slave side (outbound).
package xgate_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAKE = 2'd1,
        ST_ON   = 2'd2,
        ST_HOLD = 2'd3
    } gate_st_e;

    localparam int DOM_MST = 0;
    localparam int DOM_SLV = 1;
    localparam int NUM_DOM = 2;
endpackage

// File: rtl/xgate_dom_fsm.sv
`timescale 1ns/1ps
// Per-domain gating sequencer in the core clock domain.
// Enables on activity, reports ready after the wake delay, and disables after
// the idle hysteresis has elapsed. Assumes the delay inputs are quasi-static.
module xgate_dom_fsm
    import xgate_pkg::*;
#(
    parameter int WAKE_W   = 4,
    parameter int HOLD_W   = 8,
    parameter int DEF_WAKE = 4,
    parameter int DEF_HOLD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              want,
    input  logic [WAKE_W-1:0] wake_dly,
    input  logic [HOLD_W-1:0] idle_hold,
    output logic              en_req,
    output logic              rdy
);
    localparam int CW = (WAKE_W > HOLD_W) ? WAKE_W : HOLD_W;

    gate_st_e      st;
    logic [CW-1:0] cnt;
    logic [CW:0]   cnt_nx;
    logic [CW:0]   wake_eff;
    logic [CW:0]   hold_eff;

    // Resolve zero-programmed delays to their defaults and form the next count.
    always_comb begin
        wake_eff = (wake_dly == '0) ? (CW+1)'(DEF_WAKE) : (CW+1)'(wake_dly);
        hold_eff = (idle_hold == '0) ? (CW+1)'(DEF_HOLD) : (CW+1)'(idle_hold);
        cnt_nx   = {1'b0, cnt} + (CW+1)'(1);
    end

    // State and counter update for wake and hysteresis windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_OFF;
            cnt <= '0;
        end else begin
            case (st)
                ST_OFF: begin
                    if (want) begin
                        st  <= ST_WAKE;
                        cnt <= '0;
                    end
                end
                ST_WAKE: begin
                    if (cnt_nx >= wake_eff) st <= ST_ON;
                    else                    cnt <= cnt_nx[CW-1:0];
                end
                ST_ON: begin
                    if (!want) begin
                        st  <= ST_HOLD;
                        cnt <= '0;
                    end
                end
                default: begin
                    if (want)                    st <= ST_ON;
                    else if (cnt_nx >= hold_eff) st <= ST_OFF;
                    else                         cnt <= cnt_nx[CW-1:0];
                end
            endcase
        end
    end

    // Decode outputs from state.
    always_comb begin
        en_req = (st != ST_OFF);
        rdy    = (st == ST_ON) || (st == ST_HOLD);
    end

    // Checker-only run length of consecutive idle cycles, saturating.
    logic [CW:0] idle_run;
    always_ff @(posedge clk) begin
        if (!rst_n)          idle_run <= '0;
        else if (want)       idle_run <= '0;
        else if (~&idle_run) idle_run <= idle_run + (CW+1)'(1);
    end

    assert_off_only_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_req) |-> !$past(want));
    assert_rdy_after_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(en_req));
    assert_no_rdy_at_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_req) |-> !rdy);
    assert_hold_elapsed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_req) |-> ($past(idle_run) >= $past(hold_eff)));
endmodule

// File: rtl/xgate_en_latch.sv
`timescale 1ns/1ps
// Low-phase transparent latch that retimes an enable onto a domain clock.
// The output can only move while the domain source clock is low, so the
// downstream clock gate never sees an enable edge during a high phase.
module xgate_en_latch (
    input  logic rst_n,
    input  logic dom_clk,
    input  logic en_in,
    output logic gate_en
);
    // Pass the enable only during the low phase of the domain clock.
    always_latch begin
        if (!dom_clk) gate_en = en_in;
    end

    // Any change of the latched enable must fall inside a low phase.
    always @(gate_en) begin
        if (rst_n) begin
            assert_en_moves_low_R6: assert (!dom_clk)
                else $error("gate enable changed while domain clock high");
        end
    end
endmodule

// File: rtl/xgate_ctrl.sv
`timescale 1ns/1ps
// Root clock gating controller for a two-direction bus bridge.
// Inbound activity wakes the master-side domain, outbound activity wakes the
// slave-side domain; the core domain is never gated. The link power state is
// not an input: gating follows request, busy and debug force flags only.
module xgate_ctrl
    import xgate_pkg::*;
#(
    parameter int WAKE_W   = 4,
    parameter int HOLD_W   = 8,
    parameter int DEF_WAKE = 4,
    parameter int DEF_HOLD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        dom_clk,
    input  logic [1:0]        pend,
    input  logic [1:0]        busy,
    input  logic [1:0]        force_on,
    input  logic [WAKE_W-1:0] wake_dly,
    input  logic [HOLD_W-1:0] idle_hold,
    output logic [1:0]        en_req,
    output logic [1:0]        gate_en,
    output logic [1:0]        rdy
);
    logic [NUM_DOM-1:0] want;

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        // Activity of this direction, including the debug override.
        always_comb want[g] = pend[g] | busy[g] | force_on[g];

        xgate_dom_fsm #(
            .WAKE_W  (WAKE_W),
            .HOLD_W  (HOLD_W),
            .DEF_WAKE(DEF_WAKE),
            .DEF_HOLD(DEF_HOLD)
        ) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .want     (want[g]),
            .wake_dly (wake_dly),
            .idle_hold(idle_hold),
            .en_req   (en_req[g]),
            .rdy      (rdy[g])
        );

        xgate_en_latch u_lat (
            .rst_n  (rst_n),
            .dom_clk(dom_clk[g]),
            .en_in  (en_req[g]),
            .gate_en(gate_en[g])
        );

        assert_force_keeps_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
            force_on[g] |=> en_req[g]);
    end

    assert_inbound_wakes_mst_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[DOM_MST] | busy[DOM_MST]) |=> en_req[DOM_MST]);
    assert_outbound_wakes_slv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[DOM_SLV] | busy[DOM_SLV]) |=> en_req[DOM_SLV]);
endmodule

// File: tb/xgate_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for xgate_ctrl: one task per scenario, each checking itself.
module xgate_ctrl_tb;
    logic       clk = 1'b0;
    logic       dclk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pend = '0, busy = '0, force_on = '0;
    logic [3:0] wake_dly = '0;
    logic [7:0] idle_hold = '0;
    logic [1:0] en_req, gate_en, rdy;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    initial begin
        #2.5;
        forever #5 dclk = ~dclk;
    end

    xgate_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .dom_clk({dclk, dclk}),
        .pend(pend), .busy(busy), .force_on(force_on),
        .wake_dly(wake_dly), .idle_hold(idle_hold),
        .en_req(en_req), .gate_en(gate_en), .rdy(rdy)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // R6: enable to the clock gate may only move in the low phase.
    always @(gate_en) begin
        if (rst_n && dclk && !done) begin
            n_bad++;
            $display("FAIL R6: gate_en moved to %0b while domain clock high (expected no change)", gate_en);
        end
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R8 en_req", en_req, 0);
        chk("R8 gate_en", gate_en, 0);
        chk("R8 rdy", rdy, 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_inbound_defaults();
        wake_dly = 0; idle_hold = 0;
        pend = 2'b01;
        tick();
        chk("R1 master enabled", en_req, 2'b01);
        chk("R6 gate_en follows in low phase", gate_en, 2'b01);
        chk("R4 not ready at wake", rdy, 2'b00);
        for (int i = 1; i <= 4; i++) begin
            tick();
            if (i == 3) chk("R4 default wake not ready at 3", rdy, 2'b00);
            if (i == 4) chk("R4 default wake ready at 4", rdy, 2'b01);
        end
        pend = 2'b00;
        for (int i = 0; i <= 16; i++) begin
            tick();
            if (i == 15) chk("R5 default hold still on at 15", {rdy, en_req}, 4'b0101);
            if (i == 16) chk("R5 default hold off at 16", {rdy, en_req}, 4'b0000);
        end
        chk("R3 idle both gated", gate_en, 2'b00);
    endtask

    task automatic t_outbound_prog();
        wake_dly = 2; idle_hold = 3;
        busy = 2'b10;
        tick();
        chk("R2 slave enabled only", en_req, 2'b10);
        tick();
        chk("R4 wake 2 not ready at 1", rdy, 2'b00);
        tick();
        chk("R4 wake 2 ready at 2", rdy, 2'b10);
        busy = 2'b00;
        for (int i = 0; i <= 3; i++) begin
            tick();
            if (i == 2) chk("R5 hold 3 still on", en_req, 2'b10);
            if (i == 3) chk("R5 hold 3 off", en_req, 2'b00);
        end
    endtask

    task automatic t_rewake_in_hold();
        wake_dly = 2; idle_hold = 3;
        pend = 2'b10;
        repeat (3) tick();
        chk("R4 slave ready", rdy, 2'b10);
        pend = 2'b00;
        repeat (2) tick();
        pend = 2'b10;
        for (int i = 0; i < 6; i++) tick();
        chk("R5 rewake keeps enable", en_req, 2'b10);
        chk("R5 rewake keeps ready", rdy, 2'b10);
        pend = 2'b00;
        repeat (4) tick();
        chk("R3 off after rewake release", en_req, 2'b00);
    endtask

    task automatic t_force();
        wake_dly = 2; idle_hold = 3;
        force_on = 2'b11;
        tick();
        chk("R7 force enables both", en_req, 2'b11);
        repeat (10) tick();
        chk("R7 force holds both", {rdy, en_req}, 4'b1111);
        force_on = 2'b00;
        repeat (4) tick();
        chk("R3 off after force released", {rdy, en_req}, 4'b0000);
    endtask

    task automatic t_concurrent();
        wake_dly = 2; idle_hold = 3;
        pend = 2'b10;
        repeat (3) tick();
        pend = 2'b00;
        for (int i = 0; i <= 5; i++) begin
            tick();
            if (i == 2) pend = 2'b01;
            if (i == 3) chk("R1 R5 master wakes as slave gates", {rdy, en_req}, 4'b0001);
            if (i == 4) chk("R4 master not ready at 1", rdy, 2'b00);
            if (i == 5) chk("R4 master ready at 2", rdy, 2'b01);
        end
        pend = 2'b00;
        repeat (5) tick();
        chk("R3 all gated at end", {gate_en, en_req}, 4'b0000);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_inbound_defaults();
        t_outbound_prog();
        t_rewake_in_hold();
        t_force();
        t_concurrent();
        n_chk++;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule